// File: doc/BRIEF.md
# Grouped Event Flag Combiner

This block collects event pulses into a bank of sticky flags. The flags are split into groups of 32. Software can force flags high and knock them low through write-one registers, one set register and one clear register per group. Each group has its own interrupt mask, and the group drives a combined output that is high whenever any of its unmasked flags is high. The same flags also pass through a second, independent set of per-group exception masks. All unmasked exception flags across every group are ORed into a single exception output.

A handler reads a group's masked-flag word and takes its lowest set bit. It clears that bit through the clear register and repeats until the word reads zero. The group outputs are fed back into the bank as event numbers 0 to 3, so one group can forward the combined state of the others. A separate event-assert register raises any single flag by its number, which lets software inject events for test or signalling.

All registers are 32 bits wide at word-aligned byte addresses. Group g sits at byte offset 4*g inside each register bank. A mask bit of 1 blocks the event.

Top module: `evt_combiner`

## Requirements
- R1: After reset all flags are 0, every interrupt-mask and exception-mask bit is 1, and grp_evt and exc_out are low.
- R2: Event number N maps to group N/32, bit N%32. A high ev_in[N] on a clock edge sets that flag, and the flag stays set. ev_in[3:0] are ignored.
- R3: Writing the set register of a group (byte 0x20 + 4*g) sets each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: Writing the clear register of a group (byte 0x40 + 4*g) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R5: When an event input and a clear write hit the same flag on the same edge, the flag ends up set.
- R6: The mask register (0x80 + 4*g) reads back what was written. The masked-flag word (0xA0 + 4*g) reads flag AND NOT mask.
- R7: grp_evt[g] is high exactly when the masked-flag word of group g is nonzero.
- R8: The exception mask (0xC0 + 4*g) and the masked-exception word (0xE0 + 4*g) read flag AND NOT exception mask. exc_out is high when any masked-exception bit in any group is set. Interrupt masks have no effect on this path.
- R9: Event numbers 0 to 3 are driven by grp_evt[3:0]. While grp_evt[g] is high, flag bit g of group 0 is set on the next edge.
- R10: Writing byte address 0x1C0 sets the single flag whose event number is wdata[6:0].
- R11: The flag word of a group reads at 0x00 + 4*g. The set, clear and event-assert addresses read 0. Unused or unaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in | input | 128 | Event inputs, one per event number |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| grp_evt | output | 4 | Per-group combined event outputs |
| exc_out | output | 1 | Combined exception output |

## Verification
Flags are raised in several ways: by single-cycle event pulses in different groups, by multi-bit set writes, and by the event-assert register. This separates the event-number mapping from the register path. Clears are tried with mixed one and zero data, and once on the same edge as an event pulse to the cleared bit, which shows whether the event or the clear wins. Masks are opened one bit at a time on both the interrupt and the exception path while the other path stays closed, which shows that the two paths are independent. Opening a mask in one group and then reading group 0 shows the feedback into event numbers 0 to 3.

// File: rtl/evt_combiner.sv
module evt_combiner #(
  parameter int GROUPS = 4,
  parameter int GW     = 32,
  parameter int AW     = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUPS*GW-1:0] ev_in,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [GW-1:0]      bus_wdata,
  output logic [GW-1:0]      bus_rdata,
  output logic [GROUPS-1:0]  grp_evt,
  output logic               exc_out
);
  localparam int NEV = GROUPS * GW;
  localparam int EW  = $clog2(NEV);
  localparam logic [3:0] BK_FLAG = 4'd0, BK_SET = 4'd1, BK_CLR = 4'd2,
                         BK_MASK = 4'd4, BK_MFLG = 4'd5, BK_XMSK = 4'd6,
                         BK_XFLG = 4'd7;
  localparam logic [AW-1:0] ASSERT_ADDR = AW'(9'h1C0);

  logic [NEV-1:0] flag_q, mask_q, xmask_q;
  logic [NEV-1:0] set_v, clr_v, ast_v, ev_v, masked, xmasked;

  logic [3:0] bank;
  logic [2:0] gsel;
  logic       sel_ok;
  assign bank   = bus_addr[8:5];
  assign gsel   = bus_addr[4:2];
  assign sel_ok = (int'(gsel) < GROUPS) && (bus_addr[1:0] == 2'b00);

  assign masked  = flag_q & ~mask_q;
  assign xmasked = flag_q & ~xmask_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_comb
    assign grp_evt[g] = |masked[g*GW +: GW];
  end
  assign exc_out = |xmasked;

  always_comb begin
    ev_v = ev_in;
    ev_v[GROUPS-1:0] = grp_evt;
    set_v = '0;
    clr_v = '0;
    ast_v = '0;
    if (bus_wr && sel_ok && bank == BK_SET) set_v[gsel*GW +: GW] = bus_wdata;
    if (bus_wr && sel_ok && bank == BK_CLR) clr_v[gsel*GW +: GW] = bus_wdata;
    if (bus_wr && bus_addr == ASSERT_ADDR) ast_v[bus_wdata[EW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      mask_q  <= '1;
      xmask_q <= '1;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v | ev_v | ast_v;
      if (bus_wr && sel_ok && bank == BK_MASK) mask_q[gsel*GW +: GW]  <= bus_wdata;
      if (bus_wr && sel_ok && bank == BK_XMSK) xmask_q[gsel*GW +: GW] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ok) begin
      case (bank)
        BK_FLAG: bus_rdata = flag_q[gsel*GW +: GW];
        BK_MASK: bus_rdata = mask_q[gsel*GW +: GW];
        BK_MFLG: bus_rdata = masked[gsel*GW +: GW];
        BK_XMSK: bus_rdata = xmask_q[gsel*GW +: GW];
        BK_XFLG: bus_rdata = xmasked[gsel*GW +: GW];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module evt_combiner_chk #(
  parameter int NEV = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] ev_in,
  input logic           bus_wr,
  input logic [8:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [3:0]     grp_evt,
  input logic           exc_out,
  input logic [NEV-1:0] flag_q,
  input logic [NEV-1:0] mask_q,
  input logic [NEV-1:0] xmask_q
);
  logic [NEV-1:0] ev_eff;
  assign ev_eff = {ev_in[NEV-1:4], 4'b0};

  // R2
  ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(ev_eff)) == $past(ev_eff)));

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 9'h024) |=> ((flag_q[63:32] & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 9'h044) |=> ((flag_q[63:32] & $past(bus_wdata & ~ev_in[63:32])) == 32'd0));

  // R7
  grp_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[31:0]) |-> !grp_evt[0]);

  // R8
  exc_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&xmask_q) |-> !exc_out);
endmodule

bind evt_combiner evt_combiner_chk #(.NEV(128)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .grp_evt(grp_evt),
  .exc_out(exc_out), .flag_q(flag_q), .mask_q(mask_q), .xmask_q(xmask_q)
);

// File: tb/sim_evt_combiner.sv
module sim_evt_combiner;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] ev_in = '0;
  logic         bus_wr = 1'b0;
  logic [8:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [3:0]   grp_evt;
  logic         exc_out;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  evt_combiner u0 (.clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_evt(grp_evt), .exc_out(exc_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ev_in = '0;
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    ev_in[n] = 1'b1;
    @(negedge clk);
    ev_in[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int g = 0; g < 4; g++) begin
      rd(9'(4*g), v);          chk("R1 flag", v, 32'h0);
      rd(9'(9'h080 + 4*g), v); chk("R1 mask", v, 32'hFFFF_FFFF);
      rd(9'(9'h0C0 + 4*g), v); chk("R1 xmask", v, 32'hFFFF_FFFF);
    end
    chk("R1 grp_evt", {28'd0, grp_evt}, 32'h0);
    chk("R1 exc_out", {31'd0, exc_out}, 32'h0);
  endtask

  task automatic t_latch_set_clear();
    logic [31:0] v;
    do_reset();
    pulse(40); pulse(127); pulse(2);
    rd(9'h004, v); chk("R2 group1 flag", v, 32'h0000_0100);
    rd(9'h00C, v); chk("R2 group3 flag", v, 32'h8000_0000);
    rd(9'h000, v); chk("R2 ignored low input", v, 32'h0);
    wr(9'h028, 32'h0000_00F0);
    rd(9'h008, v); chk("R3 set", v, 32'h0000_00F0);
    wr(9'h028, 32'h0000_0000);
    rd(9'h008, v); chk("R3 zero set", v, 32'h0000_00F0);
    wr(9'h048, 32'h0000_0030);
    rd(9'h008, v); chk("R4 clear", v, 32'h0000_00C0);
    rd(9'h028, v); chk("R11 set reads zero", v, 32'h0);
    rd(9'h048, v); chk("R11 clear reads zero", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    wr(9'h024, 32'h0000_0006);
    ev_in[33] = 1'b1;
    bus_wr = 1'b1; bus_addr = 9'h044; bus_wdata = 32'h0000_0006;
    @(negedge clk);
    bus_wr = 1'b0; ev_in[33] = 1'b0;
    rd(9'h004, v); chk("R5 event beats clear", v, 32'h0000_0002);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(9'h02C, 32'h0000_0101);
    chk("R7 masked group low", {28'd0, grp_evt}, 32'h0);
    wr(9'h08C, 32'hFFFF_FFFE);
    rd(9'h08C, v); chk("R6 mask readback", v, 32'hFFFF_FFFE);
    rd(9'h0AC, v); chk("R6 masked flags", v, 32'h0000_0001);
    chk("R7 group3 out", {28'd0, grp_evt}, 32'h8);
    chk("R8 exc closed", {31'd0, exc_out}, 32'h0);
    wr(9'h08C, 32'hFFFF_FFFF);
    rd(9'h0AC, v); chk("R6 remasked", v, 32'h0);
    chk("R7 group3 off", {28'd0, grp_evt}, 32'h0);
  endtask

  task automatic t_exc();
    logic [31:0] v;
    do_reset();
    wr(9'h024, 32'h0000_0010);
    wr(9'h0C4, 32'hFFFF_FFEF);
    rd(9'h0E4, v); chk("R8 masked exc word", v, 32'h0000_0010);
    chk("R8 exc_out high", {31'd0, exc_out}, 32'h1);
    chk("R8 grp path unaffected", {28'd0, grp_evt}, 32'h0);
    wr(9'h044, 32'h0000_0010);
    chk("R8 exc_out after clear", {31'd0, exc_out}, 32'h0);
  endtask

  task automatic t_feedback();
    logic [31:0] v;
    do_reset();
    wr(9'h088, 32'hFFFF_FFDF);
    pulse(69);
    chk("R9 group2 out", {28'd0, grp_evt}, 32'h4);
    @(negedge clk);
    rd(9'h000, v); chk("R9 feedback flag", v, 32'h0000_0004);
  endtask

  task automatic t_assert_reg();
    logic [31:0] v;
    do_reset();
    wr(9'h1C0, 32'd70);
    wr(9'h1C0, 32'd100);
    rd(9'h008, v); chk("R10 assert event 70", v, 32'h0000_0040);
    rd(9'h00C, v); chk("R10 assert event 100", v, 32'h0000_0010);
    rd(9'h1C0, v); chk("R11 assert reads zero", v, 32'h0);
    wr(9'h010, 32'hFFFF_FFFF);
    rd(9'h010, v); chk("R11 unused reads zero", v, 32'h0);
    wr(9'h081, 32'h0);
    rd(9'h080, v); chk("R11 unaligned write ignored", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_latch_set_clear();
    t_collide();
    t_mask();
    t_exc();
    t_feedback();
    t_assert_reg();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule